// File: doc/BRIEF.md
# Three-Wire Serial Byte Transport Master

This block is the host side of a three-wire serial link made of a chip-enable line, a serial clock and one shared data line. Each transaction moves one byte to or from a register in the attached slave. The user supplies a 6-bit register address, a read/write selector, a byte to write and a one-cycle start request. The block answers with a done pulse and, after a read, the byte it received.

A transaction begins with a command byte that the block assembles from the address and the direction. For a write, the data byte follows on the same output line. For a read, the block stops driving the data line once the command is out and shifts the slave's reply in. Chip-enable stays high across the whole transaction. The serial clock is divided down from the system clock. Each half of a serial bit lasts `HALF_CYC` system cycles.

A complete transaction takes `33*HALF_CYC` cycles: 16 bit periods plus one guard phase with chip-enable low. The done pulse comes in the cycle after that.

Top module: `tw_byte_master`

## Requirements
- R1: The command byte has bit 7 = 1, bits 6..1 = the register address bits 5..0, and bit 0 = 1 for a read or 0 for a write.
- R2: Bits leave least-significant first. The command byte goes out first (frame bits 0..7). On a write the data byte follows (frame bits 8..15).
- R3: Chip-enable is low while idle. It rises in the first cycle after an accepted start and stays high for 16 bit periods of `2*HALF_CYC` cycles each. It then stays low for a guard phase of `HALF_CYC` cycles before done.
- R4: Every bit period is `HALF_CYC` cycles with the serial clock low, then `HALF_CYC` cycles with it high. The data output holds one value for the whole bit period, so it is already set before the clock rises.
- R5: On a read, the data output-enable falls at the start of the low phase of frame bit 8. It stays low until chip-enable falls. While it is low the data output is 0. At all other times it is high.
- R6: On a read, the data input is sampled in the last system cycle of the low phase of each of frame bits 8..15. Frame bit 8+j is stored in read-data bit j. The read-data output takes the new byte in the done cycle and holds it through later writes.
- R7: Done is a one-cycle pulse, high in cycle `33*HALF_CYC` counted from the first cycle after the accepting edge. Busy is high from the first cycle after the accepting edge through the done cycle.
- R8: A start request that arrives while busy, including during the done cycle, is ignored. It does not change the transaction in progress or the one that follows.
- R9: After a synchronous active-low reset, chip-enable, serial clock, data output, done, busy and read data are all 0, and the data output-enable is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start request, taken only when not busy |
| rnw_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 6 | Slave register address |
| wdata_i | input | 8 | Byte to write |
| rdata_o | output | 8 | Byte received by the last read |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Transaction in progress or completing |
| ce_o | output | 1 | Chip-enable to the slave |
| sclk_o | output | 1 | Serial clock to the slave |
| sdo_o | output | 1 | Serial data driven toward the slave |
| sdo_oe_o | output | 1 | Output-enable for the data line |
| sdi_i | input | 1 | Serial data read back from the data line |

## Verification
Every result is timed from the cycle after the accepting edge, called t = 0:
- Bit k has its low phase from t = 2k·H and its high phase from t = 2k·H + H.
- The guard phase starts at t = 32·H.
- Done and the new read data appear at t = 33·H.

The bench keeps its own cycle counter t and recomputes all seven outputs from it every cycle. It compares them at the falling clock edge, half a cycle after the registers update.

The bench's slave model drives the reply bit during each low phase and its inverse during each high phase. A sample taken even one cycle late therefore shows up as a wrong read byte. Start pulses sent mid-transaction, and a start held high through done, check that the accept point comes exactly one cycle after done.

// File: rtl/tw_pkg.sv
// Shared widths, state encoding and command helper for the three-wire master.
// Assumes a fixed byte of 8 bits carrying a 6-bit register address.
package tw_pkg;
    localparam int TW_BYTE_W = 8;
    localparam int TW_ADDR_W = TW_BYTE_W - 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_GAP  = 2'd3
    } tw_state_e;

    // Build the command byte: marker bit on top, address in the middle, direction at bit 0.
    function automatic logic [TW_BYTE_W-1:0] tw_make_cmd(
        input logic [TW_ADDR_W-1:0] addr,
        input logic                 is_read
    );
        return {1'b1, addr, is_read};
    endfunction
endpackage

// File: rtl/tw_phase_timer.sv
// Phase timer: counts system cycles inside one serial half-bit phase.
// Assumes: run is high for every non-idle state. The count restarts at 0 when run falls.
module tw_phase_timer #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic phase_end
);
    localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    assign phase_end = run && (cnt_q == CNT_LAST);

    // Advance the count while running and wrap at the end of each phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (phase_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LAST);
    a_r4_idle_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));
endmodule

// File: rtl/tw_rx_capture.sv
// Receive capture: stores one sampled serial bit at a selected position of the reply byte.
// Assumes the sequencer raises sample_en once per received bit.
module tw_rx_capture #(
    parameter int BYTE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sample_en,
    input  logic [$clog2(BYTE_W)-1:0] bit_sel,
    input  logic                      sdi,
    output logic [BYTE_W-1:0]         data
);
    // Write the sampled line value into the bit picked by the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
        end else if (sample_en) begin
            data[bit_sel] <= sdi;
        end
    end

    a_r6_sample_lands: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |=> (data[$past(bit_sel)] == $past(sdi)));
endmodule

// File: rtl/tw_byte_master.sv
// Three-wire byte transport master: one command byte, then one data byte either
// sent (write) or received (read), both least-significant bit first, inside one
// chip-enable window, followed by a chip-enable-low guard phase.
// Assumes HALF_CYC >= 1 and that sdi_i is already synchronous to clk.
module tw_byte_master
    import tw_pkg::*;
#(
    parameter int HALF_CYC = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 rnw_i,
    input  logic [TW_ADDR_W-1:0] addr_i,
    input  logic [TW_BYTE_W-1:0] wdata_i,
    output logic [TW_BYTE_W-1:0] rdata_o,
    output logic                 done_o,
    output logic                 busy_o,
    output logic                 ce_o,
    output logic                 sclk_o,
    output logic                 sdo_o,
    output logic                 sdo_oe_o,
    input  logic                 sdi_i
);
    localparam int FRAME_W = 2 * TW_BYTE_W;
    localparam int BIT_W   = $clog2(FRAME_W);
    localparam int SEL_W   = $clog2(TW_BYTE_W);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);

    tw_state_e            state_q;
    logic [BIT_W-1:0]     bit_q;
    logic [FRAME_W-1:0]   frame_q;
    logic                 rd_q;
    logic                 done_q;
    logic [TW_BYTE_W-1:0] rdata_q;
    logic [TW_BYTE_W-1:0] rx_byte;
    logic                 phase_end;
    logic                 accept;
    logic                 in_frame;
    logic                 rx_phase;
    logic                 sample_en;

    assign accept    = start_i && (state_q == ST_IDLE) && !done_q;
    assign in_frame  = (state_q == ST_LOW) || (state_q == ST_HIGH);
    assign rx_phase  = rd_q && bit_q[BIT_W-1];
    assign sample_en = (state_q == ST_LOW) && phase_end && rx_phase;

    tw_phase_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state_q != ST_IDLE),
        .phase_end(phase_end)
    );

    tw_rx_capture #(.BYTE_W(TW_BYTE_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_en(sample_en),
        .bit_sel  (bit_q[SEL_W-1:0]),
        .sdi      (sdi_i),
        .data     (rx_byte)
    );

    // Sequence the phases: low and high for every bit, then the guard phase, then back to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            frame_q <= '0;
            rd_q    <= 1'b0;
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= ST_LOW;
                        bit_q   <= '0;
                        rd_q    <= rnw_i;
                        frame_q <= {wdata_i, tw_make_cmd(addr_i, rnw_i)};
                    end
                end
                ST_LOW: begin
                    if (phase_end) state_q <= ST_HIGH;
                end
                ST_HIGH: begin
                    if (phase_end) begin
                        if (bit_q == BIT_LAST) begin
                            state_q <= ST_GAP;
                        end else begin
                            state_q <= ST_LOW;
                            bit_q   <= bit_q + 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (phase_end) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                        if (rd_q) rdata_q <= rx_byte;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the line outputs from the current phase and bit position.
    always_comb begin
        ce_o     = in_frame;
        sclk_o   = (state_q == ST_HIGH);
        sdo_oe_o = !(in_frame && rx_phase);
        sdo_o    = (in_frame && !rx_phase) ? frame_q[bit_q] : 1'b0;
    end

    assign done_o  = done_q;
    assign busy_o  = (state_q != ST_IDLE) || done_q;
    assign rdata_o = rdata_q;

    a_r4_sclk_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> ce_o);
    a_r4_sdo_steady_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> $stable(sdo_o));
    a_r3_ce_falls_with_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ce_o) |-> !sclk_o);
    a_r5_release_only_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe_o |-> (ce_o && !sdo_o));
    a_r7_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r7_done_while_idle_line: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_o && !ce_o));
    a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(frame_q));
endmodule

// File: tb/tw_byte_master_tb.sv
module tw_byte_master_tb;
    localparam int H    = 4;
    localparam int LAST = 33 * H - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       rnw = 1'b0;
    logic [5:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] reply_in = '0;
    logic       sdi = 1'b1;
    logic [7:0] rdata;
    logic       done, busy, ce, sclk, sdo, oe;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    tw_byte_master #(.HALF_CYC(H)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .rnw_i(rnw), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .done_o(done), .busy_o(busy),
        .ce_o(ce), .sclk_o(sclk), .sdo_o(sdo), .sdo_oe_o(oe), .sdi_i(sdi)
    );

    // Behavioural reference: cycle index since the accepting edge.
    bit        m_act = 1'b0;
    bit        m_done = 1'b0;
    int        m_t = 0;
    logic [15:0] m_frame = '0;
    logic      m_rd = 1'b0;
    logic [7:0] m_reply = '0;
    logic [7:0] m_rdata = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_act <= 1'b0; m_done <= 1'b0; m_t <= 0; m_rdata <= '0;
        end else begin
            m_done <= 1'b0;
            if (!m_act && !m_done && start) begin
                m_act   <= 1'b1;
                m_t     <= 0;
                m_frame <= {wdata, 1'b1, addr, rnw};  // R1 command layout
                m_rd    <= rnw;
                m_reply <= reply_in;
            end else if (m_act) begin
                if (m_t == LAST) begin
                    m_act  <= 1'b0;
                    m_done <= 1'b1;
                    if (m_rd) m_rdata <= m_reply;
                end else begin
                    m_t <= m_t + 1;
                end
            end
        end
    end

    task automatic check1(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", tag, what, cycles, act, exp);
        end
    endtask

    task automatic check8(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual %02h expected %02h", tag, what, cycles, act, exp);
        end
    endtask

    // Compare every output at the falling edge, then let the slave model set sdi for the next edge.
    always @(negedge clk) begin
        if (rst_n) begin
            automatic int  k   = m_t / (2 * H);
            automatic bit  hi  = (m_t % (2 * H)) >= H;
            automatic logic e_ce = 1'b0, e_sclk = 1'b0, e_sdo = 1'b0, e_oe = 1'b1;
            if (m_act && k < 16) begin
                e_ce   = 1'b1;                       // R3
                e_sclk = hi;                         // R4
                e_oe   = !(m_rd && k >= 8);          // R5
                e_sdo  = e_oe ? m_frame[k] : 1'b0;   // R2
            end
            check1("R3", "ce", ce, e_ce);
            check1("R4", "sclk", sclk, e_sclk);
            check1("R2", "sdo", sdo, e_sdo);
            check1("R5", "oe", oe, e_oe);
            check1("R7", "done", done, m_done);
            check1("R7", "busy", busy, m_act || m_done);
            check8("R6", "rdata", rdata, m_rdata);
            if (m_act && m_rd && k >= 8 && k < 16)
                sdi = hi ? ~m_reply[k-8] : m_reply[k-8];
            else
                sdi = 1'b1;
        end
    end

    task automatic wait_idle();
        while (m_act || m_done) @(negedge clk);
    endtask

    task automatic xfer(input logic rd, input logic [5:0] a, input logic [7:0] wd, input logic [7:0] rep);
        @(negedge clk);
        start = 1'b1; rnw = rd; addr = a; wdata = wd; reply_in = rep;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset values while held in reset
        check1("R9", "ce", ce, 1'b0);
        check1("R9", "sclk", sclk, 1'b0);
        check1("R9", "sdo", sdo, 1'b0);
        check1("R9", "oe", oe, 1'b1);
        check1("R9", "done", done, 1'b0);
        check1("R9", "busy", busy, 1'b0);
        check8("R9", "rdata", rdata, 8'h00);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        xfer(1'b0, 6'h00, 8'hFF, 8'h00);   // R1 R2: lowest address, all-ones data
        xfer(1'b0, 6'h3F, 8'hA5, 8'h00);   // R1: highest address
        xfer(1'b1, 6'h20, 8'h00, 8'h42);   // R5 R6: read
        xfer(1'b1, 6'h15, 8'h00, 8'h01);   // R6: only bit 0 set
        xfer(1'b0, 6'h0A, 8'h3C, 8'h00);   // R6: rdata held across a write
        xfer(1'b1, 6'h2A, 8'h00, 8'h80);   // R6: only bit 7 set

        // R8: start pulses mid-transaction with other fields are ignored
        @(negedge clk);
        start = 1'b1; rnw = 1'b0; addr = 6'h11; wdata = 8'h5A;
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        start = 1'b1; rnw = 1'b1; addr = 6'h2E; reply_in = 8'hC3;
        @(negedge clk);
        start = 1'b0;
        wait_idle();

        // R7 R8: start held high through done; next accept comes right after busy drops
        @(negedge clk);
        start = 1'b1; rnw = 1'b1; addr = 6'h07; reply_in = 8'h96;
        while (!m_done) @(negedge clk);
        rnw = 1'b0; addr = 6'h31; wdata = 8'h69;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        wait_idle();

        // R9: reset in the middle of a read returns to idle values
        @(negedge clk);
        start = 1'b1; rnw = 1'b1; addr = 6'h01; reply_in = 8'hFF;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check1("R9", "ce after reset", ce, 1'b0);
        check1("R9", "oe after reset", oe, 1'b1);
        check8("R9", "rdata after reset", rdata, 8'h00);
        rst_n = 1'b1;
        xfer(1'b1, 6'h33, 8'h00, 8'h5B);
        repeat (4) @(negedge clk);
        finish_run();
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cycles);
                finish_run();
            end
        end
    end
endmodule